// File: doc/BRIEF.md
# Two-Rail Serial Word Receiver

This block receives one return-to-zero serial channel carried on two rails and turns each framed word into a 32-bit value. The A rail high marks a one, the B rail high marks a zero, and both low marks a null. The rails are synchronised and sampled at ten samples per nominal bit time. A start is confirmed before the bit is taken. The word is then checked for null framing on both sides, for an optional 2-bit source/destination code, and for parity.

An accepted word waits in a single holding buffer. The host sees it as two 16-bit halves, chosen by a select input and read with active-low output-enable pulses. Data-ready stays asserted until both halves have been read.

A self-test selector can replace the line with a wraparound stream from a local transmitter. The rails can be swapped on the way in, so the receiver sees the complement of the data. Any change of the selector forces a long quiet period before the receiver hunts for a new word.

Top module: `a4rx_deser`

## Requirements
- R1: A sample tick occurs on every clock when `rate_slow`=0, and every `SLOW_DIV` (8) clocks when `rate_slow`=1. A nominal bit is 10 ticks: 5 with one rail high, then 5 null. Rails (A,B)=(1,0) is a one, (0,1) is a zero, (0,0) is a null, and (1,1) is illegal. An illegal symbol inside a word discards that word.
- R2: A non-null level is taken as a bit only when the same symbol is still present two ticks after it first appears. A shorter pulse is discarded and produces no word.
- R3: `len25`=0 selects 32-bit words and `len25`=1 selects 25-bit words. Serial bit 1 is received first.
- R4: A word is considered only if at least 10 consecutive null ticks precede its first bit. Bits that start sooner are ignored, up to and including the end of that stream.
- R5: After the last bit, 10 consecutive null ticks (counted from the null half of that bit) must follow. A non-null level before then discards the word. A word whose inter-bit null run reaches 8 ticks is discarded as broken.
- R6: With `sd_en`=1, a word is accepted only if serial bit 9 equals `sd_code[0]` and serial bit 10 equals `sd_code[1]`. With `sd_en`=0 the code is not checked.
- R7: Bit 8 of the first half is 0 when the received word (all 32 or 25 bits) holds an odd number of ones, and 1 when it holds an even number.
- R8: In the first half (`rd_sel`=0), bits 7:0 are serial bits 1–8 and bits 15:9 are serial bits 9–15. The second half (`rd_sel`=1) holds serial bits 16–31 for 32-bit words. For 25-bit words it holds serial bits 16–24 in bits 8:0, with bits 15:9 zero.
- R9: `ready_n` goes low after a word is accepted. While it is low, a newly completed word does not overwrite the buffer.
- R10: `ready_n` returns high on the clock that samples the falling edge of the `rd_oe_n` pulse that completes the reading of both halves, in either order. Reading the same half twice does not release the buffer.
- R11: If the releasing read and the completion of a new word fall on the same clock, the new word is kept and `ready_n` stays low.
- R12: `self_test`=1 takes the wraparound rails instead of the line. With `wrap_invert`=1 the wraparound rails are swapped, so the received data is the complement of the transmitted bits.
- R13: After `self_test` changes, a word is considered only after 100 consecutive null ticks (ten bit times).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_a | input | 1 | Line rail A (one marker) |
| line_b | input | 1 | Line rail B (zero marker) |
| wrap_a | input | 1 | Wraparound rail A from the local transmitter |
| wrap_b | input | 1 | Wraparound rail B from the local transmitter |
| wrap_invert | input | 1 | Swap wraparound rails (complemented data) |
| self_test | input | 1 | 1 selects the wraparound stream |
| rate_slow | input | 1 | 1 selects the slow sample rate |
| len25 | input | 1 | 1 selects 25-bit words |
| sd_en | input | 1 | Enable the source/destination code check |
| sd_code | input | 2 | Expected serial bits 9 (bit 0) and 10 (bit 1) |
| rd_sel | input | 1 | Half select, 0 = first half |
| rd_oe_n | input | 1 | Active-low read strobe |
| rd_data | output | 16 | Selected half of the held word |
| ready_n | output | 1 | Active-low data-ready |

## Verification
The functions that can coincide are the release of the buffer by the final read strobe and the acceptance of a newly completed word. The bench first measures, at the ports, how many clocks separate the end of a transmitted word from the fall of `ready_n`. It then places the releasing strobe at five offsets around that clock. A strobe sampled on or before the completion clock must leave `ready_n` low with the new word readable. A later strobe must leave the buffer released and the word dropped.

// File: rtl/a4rx_pkg.sv
package a4rx_pkg;

  localparam int WORD_MAX = 32;
  localparam int WORD_SHORT = 25;

  typedef enum logic [1:0] {
    SYM_NULL = 2'b00,
    SYM_ONE  = 2'b01,
    SYM_ZERO = 2'b10,
    SYM_BAD  = 2'b11
  } sym_t;

  typedef enum logic [2:0] {
    FR_HUNT, FR_CONF, FR_HIGH, FR_GAP, FR_TAIL
  } fr_state_t;

  // rail A marks a one, rail B marks a zero
  function automatic sym_t rails_to_sym(logic a, logic b);
    case ({b, a})
      2'b00:   return SYM_NULL;
      2'b01:   return SYM_ONE;
      2'b10:   return SYM_ZERO;
      default: return SYM_BAD;
    endcase
  endfunction

  // 1 when the counted bits hold an even number of ones
  function automatic logic parity_fault(logic [WORD_MAX-1:0] w, logic short_len);
    logic [WORD_MAX-1:0] m;
    m = short_len ? {{(WORD_MAX-WORD_SHORT){1'b0}}, {WORD_SHORT{1'b1}}} : '1;
    return ~(^(w & m));
  endfunction

  function automatic logic [15:0] first_half(logic [WORD_MAX-1:0] w, logic pf);
    return {w[14:8], pf, w[7:0]};
  endfunction

  function automatic logic [15:0] second_half(logic [WORD_MAX-1:0] w, logic short_len);
    return short_len ? {7'd0, w[23:15]} : w[30:15];
  endfunction

endpackage

// File: rtl/a4rx_sampler.sv
module a4rx_sampler
  import a4rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SLOW_DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_a,
  input  logic line_b,
  input  logic wrap_a,
  input  logic wrap_b,
  input  logic wrap_invert,
  input  logic self_test,
  input  logic rate_slow,
  output logic tick,
  output sym_t sym
);
  localparam int DIV_W = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_TOP = DIV_W'(SLOW_DIV - 1);

  logic pick_a, pick_b;
  logic [SYNC_STAGES-1:0] sa, sb;
  logic [DIV_W-1:0] dcnt;

  always_comb begin
    if (self_test) begin
      pick_a = wrap_invert ? wrap_b : wrap_a;
      pick_b = wrap_invert ? wrap_a : wrap_b;
    end else begin
      pick_a = line_a;
      pick_b = line_b;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sa   <= '0;
      sb   <= '0;
      dcnt <= '0;
    end else begin
      sa   <= {sa[SYNC_STAGES-2:0], pick_a};
      sb   <= {sb[SYNC_STAGES-2:0], pick_b};
      dcnt <= (dcnt == DIV_TOP) ? '0 : dcnt + 1'b1;
    end
  end

  assign tick = !rate_slow || (dcnt == '0);
  assign sym  = rails_to_sym(sa[SYNC_STAGES-1], sb[SYNC_STAGES-1]);
endmodule

// File: rtl/a4rx_framer.sv
module a4rx_framer
  import a4rx_pkg::*;
#(
  parameter int SAMPLES_PER_BIT = 10,
  parameter int CONFIRM_TICKS = 2,
  parameter int QUIET_BITS = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  sym_t                sym,
  input  logic                len25,
  input  logic                mode_chg,
  output logic                word_done,
  output logic [WORD_MAX-1:0] word,
  output logic                quiet_wait
);
  localparam int QUIET_TICKS = QUIET_BITS * SAMPLES_PER_BIT;
  localparam int RUN_W = $clog2(QUIET_TICKS + 1);
  localparam int TK_W  = $clog2(SAMPLES_PER_BIT);
  localparam int IDX_W = $clog2(WORD_MAX + 1);
  localparam int POS_W = $clog2(WORD_MAX);
  localparam logic [RUN_W-1:0] RUN_TOP = '1;
  localparam logic [RUN_W-1:0] QUIET_L = RUN_W'(QUIET_TICKS);
  localparam logic [RUN_W-1:0] BIT_L   = RUN_W'(SAMPLES_PER_BIT);
  localparam logic [RUN_W-1:0] GAP_L   = RUN_W'(SAMPLES_PER_BIT - 3);
  localparam logic [RUN_W-1:0] TAIL_L  = RUN_W'(SAMPLES_PER_BIT - 1);
  localparam logic [TK_W-1:0]  CONF_L  = TK_W'(CONFIRM_TICKS - 1);
  localparam logic [TK_W-1:0]  HIGH_L  = TK_W'(SAMPLES_PER_BIT - 2);

  fr_state_t st;
  sym_t cand;
  logic [RUN_W-1:0] nrun;
  logic [TK_W-1:0] tk;
  logic [IDX_W-1:0] bidx, len_bits;
  logic is_bit, armed;

  assign is_bit   = (sym == SYM_ONE) || (sym == SYM_ZERO);
  assign armed    = quiet_wait ? (nrun >= QUIET_L) : (nrun >= BIT_L);
  assign len_bits = len25 ? IDX_W'(WORD_SHORT) : IDX_W'(WORD_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= FR_HUNT;  cand <= SYM_NULL;  nrun <= '0;  tk <= '0;
      bidx <= '0;  word <= '0;  word_done <= 1'b0;  quiet_wait <= 1'b0;
    end else begin
      word_done <= 1'b0;
      if (mode_chg) begin
        st <= FR_HUNT;
        nrun <= '0;
        quiet_wait <= 1'b1;
      end else if (tick) begin
        nrun <= (sym != SYM_NULL) ? '0 : (nrun == RUN_TOP) ? nrun : nrun + 1'b1;
        case (st)
          FR_HUNT: if (is_bit && armed) begin
            st <= FR_CONF;  cand <= sym;  tk <= '0;
            bidx <= '0;  word <= '0;  quiet_wait <= 1'b0;
          end
          FR_CONF: begin
            if (sym != cand) st <= FR_HUNT;
            else if (tk == CONF_L) begin
              word[bidx[POS_W-1:0]] <= (cand == SYM_ONE);
              bidx <= bidx + 1'b1;
              st   <= FR_HIGH;
            end
            tk <= tk + 1'b1;
          end
          FR_HIGH: begin
            if (sym == SYM_NULL) st <= (bidx == len_bits) ? FR_TAIL : FR_GAP;
            else if (sym != cand || tk == HIGH_L) st <= FR_HUNT;
            tk <= tk + 1'b1;
          end
          FR_GAP: begin
            if (is_bit) begin
              st <= FR_CONF;  cand <= sym;  tk <= '0;
            end else if (sym == SYM_BAD || nrun >= GAP_L) st <= FR_HUNT;
          end
          FR_TAIL: begin
            if (sym != SYM_NULL) st <= FR_HUNT;
            else if (nrun == TAIL_L) begin
              word_done <= 1'b1;
              st <= FR_HUNT;
            end
          end
          default: st <= FR_HUNT;
        endcase
      end
    end
  end
endmodule

// File: rtl/a4rx_holdbuf.sv
module a4rx_holdbuf
  import a4rx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                word_done,
  input  logic [WORD_MAX-1:0] word,
  input  logic                len25,
  input  logic                sd_en,
  input  logic [1:0]          sd_code,
  input  logic                rd_sel,
  input  logic                rd_oe_n,
  output logic [15:0]         rd_data,
  output logic                ready_n,
  output logic                acc_pulse,
  output logic                clr_pulse
);
  logic full, oe_q, oe_fall, code_ok;
  logic [1:0] seen, seen_next;
  logic [15:0] h1, h2;

  assign oe_fall   = oe_q && !rd_oe_n;
  assign seen_next = seen | (rd_sel ? 2'b10 : 2'b01);
  assign clr_pulse = full && oe_fall && (&seen_next);
  assign code_ok   = !sd_en || ({word[9], word[8]} == sd_code);
  assign acc_pulse = word_done && code_ok && (!full || clr_pulse);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;  oe_q <= 1'b1;  seen <= '0;  h1 <= '0;  h2 <= '0;
    end else begin
      oe_q <= rd_oe_n;
      if (acc_pulse) begin
        h1   <= first_half(word, parity_fault(word, len25));
        h2   <= second_half(word, len25);
        full <= 1'b1;
        seen <= '0;
      end else if (clr_pulse) begin
        full <= 1'b0;
        seen <= '0;
      end else if (full && oe_fall) begin
        seen <= seen_next;
      end
    end
  end

  assign rd_data = rd_sel ? h2 : h1;
  assign ready_n = !full;
endmodule

// File: rtl/a4rx_deser.sv
module a4rx_deser
  import a4rx_pkg::*;
#(
  parameter int SAMPLES_PER_BIT = 10,
  parameter int CONFIRM_TICKS = 2,
  parameter int QUIET_BITS = 10,
  parameter int SLOW_DIV = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        line_a,
  input  logic        line_b,
  input  logic        wrap_a,
  input  logic        wrap_b,
  input  logic        wrap_invert,
  input  logic        self_test,
  input  logic        rate_slow,
  input  logic        len25,
  input  logic        sd_en,
  input  logic [1:0]  sd_code,
  input  logic        rd_sel,
  input  logic        rd_oe_n,
  output logic [15:0] rd_data,
  output logic        ready_n
);
  logic tick, st_q, mode_chg, word_done, quiet_wait, acc_pulse, clr_pulse;
  sym_t sym;
  logic [WORD_MAX-1:0] word;

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= 1'b0;
    else        st_q <= self_test;
  end
  assign mode_chg = st_q ^ self_test;

  a4rx_sampler #(.SYNC_STAGES(SYNC_STAGES), .SLOW_DIV(SLOW_DIV)) u_smp (
    .clk(clk), .rst_n(rst_n), .line_a(line_a), .line_b(line_b),
    .wrap_a(wrap_a), .wrap_b(wrap_b), .wrap_invert(wrap_invert),
    .self_test(self_test), .rate_slow(rate_slow), .tick(tick), .sym(sym));

  a4rx_framer #(.SAMPLES_PER_BIT(SAMPLES_PER_BIT), .CONFIRM_TICKS(CONFIRM_TICKS),
                .QUIET_BITS(QUIET_BITS)) u_frm (
    .clk(clk), .rst_n(rst_n), .tick(tick), .sym(sym), .len25(len25),
    .mode_chg(mode_chg), .word_done(word_done), .word(word), .quiet_wait(quiet_wait));

  a4rx_holdbuf u_buf (
    .clk(clk), .rst_n(rst_n), .word_done(word_done), .word(word), .len25(len25),
    .sd_en(sd_en), .sd_code(sd_code), .rd_sel(rd_sel), .rd_oe_n(rd_oe_n),
    .rd_data(rd_data), .ready_n(ready_n), .acc_pulse(acc_pulse), .clr_pulse(clr_pulse));
endmodule

// File: rtl/a4rx_checker.sv
module a4rx_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        ready_n,
  input logic [15:0] rd_data,
  input logic        rd_sel,
  input logic        sd_en,
  input logic [1:0]  sd_code,
  input logic        acc_pulse,
  input logic        clr_pulse,
  input logic        quiet_wait
);
  a_r9_ready_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    acc_pulse |=> !ready_n);

  a_r9_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready_n && !clr_pulse) |=> (rd_sel != $past(rd_sel) || $stable(rd_data)));

  a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_pulse && !acc_pulse) |=> ready_n);

  a_r10_only_read_releases: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_n) |-> $past(clr_pulse));

  a_r11_keep_on_collision: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_pulse && clr_pulse) |=> !ready_n);

  a_r6_code_match: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_pulse && sd_en) |=> (rd_sel || rd_data[10:9] == $past(sd_code)));

  a_r13_quiet_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    quiet_wait |-> !acc_pulse);
endmodule

bind a4rx_deser a4rx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .ready_n(ready_n), .rd_data(rd_data), .rd_sel(rd_sel),
  .sd_en(sd_en), .sd_code(sd_code), .acc_pulse(acc_pulse), .clr_pulse(clr_pulse),
  .quiet_wait(quiet_wait));

// File: tb/tb_a4rx_deser.sv
`timescale 1ns/1ps
module tb_a4rx_deser;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, line_a, line_b, wrap_a, wrap_b, wrap_invert, self_test;
  logic rate_slow, len25, sd_en, rd_sel, rd_oe_n, ready_n;
  logic [1:0] sd_code;
  logic [15:0] rd_data;

  int nchk = 0, nbad = 0, cyc = 0, lat = 9;
  bit on_wrap = 0, finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  a4rx_deser dut (.*);

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_lo(logic [31:0] w, bit l25);
    int n, ones;
    logic [15:0] r;
    n = l25 ? 25 : 32;
    ones = 0;
    r = '0;
    for (int i = 0; i < n; i++) ones += w[i];
    for (int i = 0; i < 16; i++) begin
      if (i < 8) r[i] = w[i];
      else if (i > 8) r[i] = w[i-1];
    end
    r[8] = (ones % 2 == 0);
    return r;
  endfunction

  function automatic logic [15:0] exp_hi(logic [31:0] w, bit l25);
    int n;
    logic [15:0] r;
    n = l25 ? 25 : 32;
    r = '0;
    for (int i = 0; i < 16; i++) if (15 + i <= n - 2) r[i] = w[15+i];
    return r;
  endfunction

  task automatic set_rails(input logic a, input logic b);
    if (on_wrap) begin wrap_a = a; wrap_b = b; end
    else begin line_a = a; line_b = b; end
  endtask

  task automatic idle(input int n);
    set_rails(0, 0);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_sym(input logic a, input logic b);
    int half;
    half = rate_slow ? 40 : 5;
    set_rails(a, b);
    repeat (half) @(negedge clk);
    set_rails(0, 0);
    repeat (half) @(negedge clk);
  endtask

  task automatic send_word(input logic [31:0] w, input int n);
    for (int i = 0; i < n; i++) put_sym(w[i], !w[i]);
  endtask

  task automatic oe_pulse(input logic s, output logic [15:0] d);
    rd_sel = s;
    rd_oe_n = 0;
    #1 d = rd_data;
    @(negedge clk);
    rd_oe_n = 1;
    @(negedge clk);
  endtask

  task automatic expect_word(input logic [31:0] w, input bit l25, input string tag);
    logic [15:0] a, b;
    check(ready_n == 0, {tag, " ready"}, ready_n, 0);
    oe_pulse(0, a);
    oe_pulse(1, b);
    check(a == exp_lo(w, l25), {tag, " half1"}, a, exp_lo(w, l25));
    check(b == exp_hi(w, l25), {tag, " half2"}, b, exp_hi(w, l25));
    check(ready_n == 1, {tag, " R10 released"}, ready_n, 1);
  endtask

  task automatic expect_none(input string tag);
    check(ready_n == 1, tag, ready_n, 1);
  endtask

  task automatic wait_done();
    repeat (lat + 3) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nchk++;
      nbad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin
    logic [31:0] w, w2;
    logic [15:0] t;
    int t0;
    void'($urandom(32'h5eed_0429));
    rst_n = 0; line_a = 0; line_b = 0; wrap_a = 0; wrap_b = 0; wrap_invert = 0;
    self_test = 0; rate_slow = 0; len25 = 0; sd_en = 0; sd_code = 0;
    rd_sel = 0; rd_oe_n = 1;
    repeat (5) @(negedge clk);
    rst_n = 1;
    check(ready_n == 1, "R9 reset ready_n", ready_n, 1);
    idle(30);

    // R3 R8 R7: first word, latency measured at the ports
    w = 32'h6A3C_51E7;
    send_word(w, 32);
    t0 = cyc;
    while (ready_n && cyc < t0 + 80) @(negedge clk);
    lat = cyc - t0;
    check(ready_n == 0, "R9 accept first word", ready_n, 0);
    // R9: second word while full is not stored
    send_word(32'h1234_5678, 32);
    wait_done();
    expect_word(w, 0, "R9 R3 R8 no overwrite");

    // R7: odd and even ones count
    idle(20);
    send_word(32'h0000_0001, 32); wait_done();
    expect_word(32'h0000_0001, 0, "R7 odd count");
    send_word(32'h0000_0003, 32); wait_done();
    expect_word(32'h0000_0003, 0, "R7 even count");

    // R3 R8: 25-bit word
    len25 = 1;
    idle(20);
    w = 32'h01C3_A5F1;
    send_word(w, 25); wait_done();
    expect_word(w, 1, "R3 R8 25-bit");
    len25 = 0;
    idle(20);

    // R6: source/destination filter, X=serial bit 9 (0), Y=serial bit 10 (1)
    sd_en = 1; sd_code = 2'b10;
    w = 32'h0000_0200;
    send_word(w, 32); wait_done();
    expect_word(w, 0, "R6 code match");
    send_word(32'h0000_0100, 32); wait_done();
    expect_none("R6 code mismatch ignored");
    sd_en = 0;
    send_word(32'h0000_0100, 32); wait_done();
    expect_word(32'h0000_0100, 0, "R6 check disabled");

    // R2: short pulse ignored, then a real word
    set_rails(1, 0); repeat (2) @(negedge clk);
    idle(30);
    expect_none("R2 glitch ignored");
    w = 32'hCAFE_0F0F;
    send_word(w, 32); wait_done();
    expect_word(w, 0, "R2 word after glitch");

    // R4 R1: illegal symbol leaves too little leading null
    put_sym(1, 1);
    send_word(32'h5555_AAAA, 32); wait_done();
    expect_none("R4 no leading null");
    idle(20);
    // R5: extra trailing bit, and broken word
    send_word(32'h0F0F_3C3C, 32);
    put_sym(1, 0); wait_done();
    expect_none("R5 no trailing null");
    idle(20);
    send_word(32'h000F_FFFF, 20);
    idle(40);
    expect_none("R5 broken word");
    // R1: illegal symbol mid-word
    send_word(32'h3333_3333, 10);
    put_sym(1, 1);
    send_word(32'h0000_0000, 21); wait_done();
    expect_none("R1 illegal symbol inside word");
    idle(20);

    // R1: slow rate
    rate_slow = 1;
    idle(120);
    w = 32'h9ABC_DEF0;
    send_word(w, 32);
    repeat (200) @(negedge clk);
    expect_word(w, 0, "R1 slow rate");
    rate_slow = 0;
    idle(20);

    // R12: wraparound, plain then swapped rails
    self_test = 1;
    idle(120);
    send_word(32'h7777_1111, 32); wait_done();
    expect_none("R12 line ignored in self-test");
    on_wrap = 1;
    w = 32'h2468_ACE1;
    send_word(w, 32); wait_done();
    expect_word(w, 0, "R12 wraparound");
    wrap_invert = 1;
    send_word(w, 32); wait_done();
    expect_word(~w, 0, "R12 inverted wraparound");
    on_wrap = 0;
    wrap_invert = 0;

    // R13: back to line with a short quiet time
    self_test = 0;
    idle(50);
    send_word(32'h1357_9BDF, 32); wait_done();
    expect_none("R13 quiet not reached");
    idle(120);
    w = 32'hFEDC_BA98;
    send_word(w, 32); wait_done();
    expect_word(w, 0, "R13 after quiet");

    // R10: same half twice, then reverse order
    send_word(w, 32); wait_done();
    oe_pulse(0, t); oe_pulse(0, t);
    check(ready_n == 0, "R10 same half twice", ready_n, 0);
    oe_pulse(1, t);
    check(ready_n == 1, "R10 release", ready_n, 1);
    send_word(w, 32); wait_done();
    oe_pulse(1, t);
    check(t == exp_hi(w, 0), "R10 reverse half2", t, exp_hi(w, 0));
    oe_pulse(0, t);
    check(t == exp_lo(w, 0), "R10 reverse half1", t, exp_lo(w, 0));
    check(ready_n == 1, "R10 reverse release", ready_n, 1);

    // R11: releasing read around the completion clock
    for (int d = -2; d <= 2; d++) begin
      w  = 32'hA5A5_0000 | 32'(d + 8);
      w2 = 32'h5A5A_1000 | 32'(d + 8);
      send_word(w, 32); wait_done();
      oe_pulse(0, t);
      send_word(w2, 32);
      t0 = cyc;
      while (cyc < t0 + lat + d - 1) @(negedge clk);
      rd_sel = 1; rd_oe_n = 0;
      @(negedge clk);
      rd_oe_n = 1;
      repeat (6) @(negedge clk);
      if (d <= 0) expect_word(w2, 0, "R11 collision keeps word");
      else expect_none("R11 late read drops word");
      idle(10);
    end

    // random words, random length and filter
    for (int k = 0; k < 24; k++) begin
      bit l25, en, hit;
      logic [1:0] c;
      w = $urandom;
      l25 = $urandom_range(0, 1);
      en = $urandom_range(0, 1);
      c = 2'($urandom_range(0, 3));
      len25 = l25; sd_en = en; sd_code = c;
      idle(15);
      send_word(w, l25 ? 25 : 32); wait_done();
      hit = !en || ({w[9], w[8]} == c);
      if (hit) expect_word(w, l25, "R6 R3 random accept");
      else expect_none("R6 random reject");
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule